// File: doc/BRIEF.md
# x86 ModR/M Effective Address Generator

This unit turns the addressing bytes of an x86 instruction into a linear memory address. It reads the ModR/M byte and the bytes that follow it: an optional SIB byte and up to four displacement bytes. It also reads the eight general registers, the data and stack segment bases, and a few mode controls. It reports three things: the linear address, whether the operand is a register rather than memory (and if so which one), and the number of instruction bytes that the opcode and its addressing bytes use.

Both addressing sizes are covered. In 16-bit mode the unit uses the classic table of register pairs, and the offset wraps to 16 bits. In 32-bit mode it handles the single-register forms and the SIB scaled-index forms, including the special encodings with no base and no index. An effective-offset control forces both segment bases to zero, as an address-load instruction needs. A valid strobe starts a computation, and the results appear on registered outputs one cycle later.

Top module: `modrm_addr_unit`

## Requirements
- R1: ModR/M bits 7:6 are mod and bits 2:0 are r/m. In 16-bit mode the r/m values 0 to 7 select BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX, using the low 16 bits of registers 3 (BX), 5 (BP), 6 (SI) and 7 (DI). The offset, displacement included, wraps to 16 bits before the segment base is added.
- R2: In 16-bit mode with mod=0 and r/m=6, the offset is the 16-bit displacement alone, with no BP. The length is 4 and the DS base is used.
- R3: The SS base is used when the base register is BP or EBP, and in SIB forms also when it is ESP. Every other memory form, including the direct-displacement forms, uses the DS base.
- R4: mod=1 adds an 8-bit displacement, sign-extended. mod=2 adds a 16-bit displacement in 16-bit mode and a 32-bit displacement in 32-bit mode. Displacement bytes are little-endian in the follow bytes, starting at follow byte 0, or at follow byte 1 when a SIB byte is present.
- R5: In 32-bit mode, r/m=4 with mod below 3 takes follow byte 0 as SIB: scale in bits 7:6, index in bits 5:3, base in bits 2:0. The address is base + (index << scale) + displacement.
- R6: A SIB index of 4 adds no index, whatever the scale. A SIB base of 5 with mod=0 replaces the base register by a 32-bit displacement taken from follow bytes 1 to 4, and uses DS.
- R7: In 32-bit mode with mod=0 and r/m=5, the address is the DS base plus the 32-bit displacement in follow bytes 0 to 3. The length is 6.
- R8: The length counts the opcode byte. It is 2 for register forms and plain indirect forms, 3 for mod=1 without SIB, 4 for 16-bit mod=2, 6 for 32-bit mod=2 without SIB, 3 for mod=0 with SIB, 4 for mod=1 with SIB, and 7 for SIB with a 32-bit displacement.
- R9: mod=3 sets the register flag, sets the address to 0 and returns r/m as the register index with the high-byte flag clear. When byte size is requested and r/m is 4 to 7, the index is r/m-4 and the high-byte flag is set (AH, CH, DH, BH).
- R10: With the effective-offset control set, both segment bases count as zero.
- R11: The outputs load one cycle after a valid strobe, with valid out high for exactly that cycle, and hold while no strobe arrives. Reset clears them to zero. The 32-bit address sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Start a computation with the present inputs |
| addr16_i | input | 1 | 1: 16-bit addressing, 0: 32-bit |
| lea_i | input | 1 | Treat both segment bases as zero |
| byte_reg_i | input | 1 | Register operand is byte-sized |
| modrm_i | input | 8 | ModR/M byte |
| follow_i | input | 40 | Five bytes after ModR/M, byte 0 in bits 7:0 |
| gpr_i | input | 8x32 | General registers, index 0..7 = EAX..EDI |
| ds_base_i | input | 32 | Data segment base |
| ss_base_i | input | 32 | Stack segment base |
| valid_o | output | 1 | Results loaded this cycle |
| addr_o | output | 32 | Linear address (0 for register forms) |
| is_reg_o | output | 1 | Operand is a register |
| reg_idx_o | output | 3 | Register index for register forms |
| reg_hi_o | output | 1 | Byte register is the high byte of reg_idx_o |
| len_o | output | 3 | Bytes used by opcode, ModR/M, SIB and displacement |

## Verification
Random ModR/M, SIB and follow bytes are applied with random register values, random segment bases and random mode controls, so every mod and r/m pair is reached in both address sizes. Giving the registers and the two bases distinct values makes a wrong register pick or a wrong segment choice visible in the address. Directed cases use carries that separate 16-bit wrapping from a full-width sum, negative 8-bit displacements that separate sign extension from zero extension, and the no-base, no-index, ESP and byte-register encodings. Holding the inputs after a strobe and then changing them separates a registered output from one that follows the inputs.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned NUM_GPR      = 8;
  localparam int unsigned GPR_IDX_W    = $clog2(NUM_GPR);
  localparam int unsigned OFF16_W      = 16;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned DISP_BYTES   = WORD_W / BYTE_W;
  localparam int unsigned FOLLOW_BYTES = DISP_BYTES + 1;
  localparam int unsigned FOLLOW_W     = FOLLOW_BYTES * BYTE_W;
  localparam int unsigned LEN_W        = 3;

  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [GPR_IDX_W-1:0] gidx_t;
  typedef logic [LEN_W-1:0]     len_t;

  typedef enum logic [1:0] {
    MOD_NODISP = 2'd0,
    MOD_DISP8  = 2'd1,
    MOD_DISPW  = 2'd2,
    MOD_REG    = 2'd3
  } mod_e;

  typedef struct packed {
    mod_e  mode;
    gidx_t reg_f;
    gidx_t rm;
  } modrm_t;

  typedef struct packed {
    logic [1:0] scale;
    gidx_t      index;
    gidx_t      base;
  } sib_t;

  localparam gidx_t GPR_BX = 3'd3;
  localparam gidx_t GPR_SP = 3'd4;
  localparam gidx_t GPR_BP = 3'd5;
  localparam gidx_t GPR_SI = 3'd6;
  localparam gidx_t GPR_DI = 3'd7;

  localparam gidx_t RM_SIB    = 3'd4;
  localparam gidx_t RM_DIR32  = 3'd5;
  localparam gidx_t RM_DIR16  = 3'd6;
  localparam gidx_t IDX_NONE  = 3'd4;
  localparam gidx_t BASE_NONE = 3'd5;

  localparam len_t LEN_BARE    = 3'd2;
  localparam len_t LEN_D8      = 3'd3;
  localparam len_t LEN_SIB     = 3'd3;
  localparam len_t LEN_D16     = 3'd4;
  localparam len_t LEN_SIB_D8  = 3'd4;
  localparam len_t LEN_D32     = 3'd6;
  localparam len_t LEN_SIB_D32 = 3'd7;
endpackage

// File: rtl/ea_len_disp.sv
module ea_len_disp
  import ea_pkg::*;
(
  input  modrm_t                modrm_i,
  input  logic [FOLLOW_W-1:0]   follow_i,
  input  logic                  addr16_i,
  output logic                  has_sib_o,
  output logic                  base_none_o,
  output len_t                  len_o,
  output word_t                 disp_o
);
  logic [BYTE_W-1:0] fb [FOLLOW_BYTES];
  logic [BYTE_W-1:0] db [DISP_BYTES];
  sib_t              sib;
  logic [WORD_W-1:0] d8_sx, d16_sx, d32;

  for (genvar g = 0; g < FOLLOW_BYTES; g++) begin : g_fb
    assign fb[g] = follow_i[g*BYTE_W +: BYTE_W];
  end

  // displacement starts one byte later when SIB is present
  for (genvar g = 0; g < DISP_BYTES; g++) begin : g_db
    assign db[g] = has_sib_o ? fb[g+1] : fb[g];
  end

  assign sib = sib_t'(fb[0]);

  always_comb begin
    has_sib_o   = !addr16_i && (modrm_i.mode != MOD_REG) && (modrm_i.rm == RM_SIB);
    base_none_o = has_sib_o && (modrm_i.mode == MOD_NODISP) && (sib.base == BASE_NONE);
  end

  always_comb begin
    d8_sx  = {{(WORD_W-BYTE_W){db[0][BYTE_W-1]}}, db[0]};
    d16_sx = {{(WORD_W-2*BYTE_W){db[1][BYTE_W-1]}}, db[1], db[0]};
    d32    = {db[3], db[2], db[1], db[0]};
  end

  always_comb begin
    len_o  = LEN_BARE;
    disp_o = '0;
    if (addr16_i) begin
      unique case (modrm_i.mode)
        MOD_NODISP: if (modrm_i.rm == RM_DIR16) begin
          len_o  = LEN_D16;
          disp_o = d16_sx;
        end
        MOD_DISP8: begin
          len_o  = LEN_D8;
          disp_o = d8_sx;
        end
        MOD_DISPW: begin
          len_o  = LEN_D16;
          disp_o = d16_sx;
        end
        default: ;
      endcase
    end else begin
      unique case (modrm_i.mode)
        MOD_NODISP: begin
          if (has_sib_o) begin
            len_o = base_none_o ? LEN_SIB_D32 : LEN_SIB;
            if (base_none_o) disp_o = d32;
          end else if (modrm_i.rm == RM_DIR32) begin
            len_o  = LEN_D32;
            disp_o = d32;
          end
        end
        MOD_DISP8: begin
          len_o  = has_sib_o ? LEN_SIB_D8 : LEN_D8;
          disp_o = d8_sx;
        end
        MOD_DISPW: begin
          len_o  = has_sib_o ? LEN_SIB_D32 : LEN_D32;
          disp_o = d32;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ea_off16.sv
module ea_off16
  import ea_pkg::*;
(
  input  modrm_t               modrm_i,
  input  logic [OFF16_W-1:0]   bx_i,
  input  logic [OFF16_W-1:0]   bp_i,
  input  logic [OFF16_W-1:0]   si_i,
  input  logic [OFF16_W-1:0]   di_i,
  input  logic [OFF16_W-1:0]   disp_i,
  output logic [OFF16_W-1:0]   off_o,
  output logic                 use_ss_o
);
  logic [OFF16_W-1:0] base_sum;

  always_comb begin
    unique case (modrm_i.rm)
      3'd0: base_sum = bx_i + si_i;
      3'd1: base_sum = bx_i + di_i;
      3'd2: base_sum = bp_i + si_i;
      3'd3: base_sum = bp_i + di_i;
      3'd4: base_sum = si_i;
      3'd5: base_sum = di_i;
      3'd6: base_sum = (modrm_i.mode == MOD_NODISP) ? '0 : bp_i;
      default: base_sum = bx_i;
    endcase
  end

  assign off_o = base_sum + disp_i;

  always_comb begin
    unique case (modrm_i.rm)
      3'd2, 3'd3: use_ss_o = 1'b1;
      3'd6:       use_ss_o = (modrm_i.mode != MOD_NODISP);
      default:    use_ss_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ea_off32.sv
module ea_off32
  import ea_pkg::*;
(
  input  modrm_t                          modrm_i,
  input  sib_t                            sib_i,
  input  logic                            has_sib_i,
  input  logic                            base_none_i,
  input  logic [NUM_GPR-1:0][WORD_W-1:0]  gpr_i,
  input  word_t                           disp_i,
  output word_t                           off_o,
  output logic                            use_ss_o
);
  word_t base_val, idx_val;
  logic  direct;

  assign direct = !has_sib_i && (modrm_i.mode == MOD_NODISP) && (modrm_i.rm == RM_DIR32);

  always_comb begin
    if (has_sib_i) begin
      base_val = base_none_i ? '0 : gpr_i[sib_i.base];
      idx_val  = (sib_i.index == IDX_NONE) ? '0 : (gpr_i[sib_i.index] << sib_i.scale);
      use_ss_o = !base_none_i && ((sib_i.base == GPR_SP) || (sib_i.base == GPR_BP));
    end else begin
      base_val = direct ? '0 : gpr_i[modrm_i.rm];
      idx_val  = '0;
      use_ss_o = !direct && (modrm_i.rm == GPR_BP);
    end
  end

  assign off_o = base_val + idx_val + disp_i;
endmodule

// File: rtl/modrm_addr_unit.sv
module modrm_addr_unit
  import ea_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          addr16_i,
  input  logic                          lea_i,
  input  logic                          byte_reg_i,
  input  logic [BYTE_W-1:0]             modrm_i,
  input  logic [FOLLOW_W-1:0]           follow_i,
  input  logic [NUM_GPR-1:0][WORD_W-1:0] gpr_i,
  input  logic [WORD_W-1:0]             ds_base_i,
  input  logic [WORD_W-1:0]             ss_base_i,
  output logic                          valid_o,
  output logic [WORD_W-1:0]             addr_o,
  output logic                          is_reg_o,
  output logic [GPR_IDX_W-1:0]          reg_idx_o,
  output logic                          reg_hi_o,
  output logic [LEN_W-1:0]              len_o
);
  modrm_t              mrm;
  sib_t                sib;
  logic                has_sib, base_none;
  len_t                len_c;
  word_t               disp;
  logic [OFF16_W-1:0]  off16;
  word_t               off32;
  logic                ss16, ss32, use_ss;
  word_t               seg, addr_c;
  logic                is_reg_c, hi_c;
  gidx_t               idx_c;
  logic                unused_reg_field;

  assign mrm = modrm_t'(modrm_i);
  assign sib = sib_t'(follow_i[BYTE_W-1:0]);
  assign unused_reg_field = ^mrm.reg_f;

  ea_len_disp u_len (
    .modrm_i     (mrm),
    .follow_i    (follow_i),
    .addr16_i    (addr16_i),
    .has_sib_o   (has_sib),
    .base_none_o (base_none),
    .len_o       (len_c),
    .disp_o      (disp)
  );

  ea_off16 u_off16 (
    .modrm_i  (mrm),
    .bx_i     (gpr_i[GPR_BX][OFF16_W-1:0]),
    .bp_i     (gpr_i[GPR_BP][OFF16_W-1:0]),
    .si_i     (gpr_i[GPR_SI][OFF16_W-1:0]),
    .di_i     (gpr_i[GPR_DI][OFF16_W-1:0]),
    .disp_i   (disp[OFF16_W-1:0]),
    .off_o    (off16),
    .use_ss_o (ss16)
  );

  ea_off32 u_off32 (
    .modrm_i     (mrm),
    .sib_i       (sib),
    .has_sib_i   (has_sib),
    .base_none_i (base_none),
    .gpr_i       (gpr_i),
    .disp_i      (disp),
    .off_o       (off32),
    .use_ss_o    (ss32)
  );

  always_comb begin
    use_ss = addr16_i ? ss16 : ss32;
    if (lea_i)       seg = '0;
    else if (use_ss) seg = ss_base_i;
    else             seg = ds_base_i;
  end

  always_comb begin
    is_reg_c = (mrm.mode == MOD_REG);
    hi_c     = 1'b0;
    idx_c    = mrm.rm;
    addr_c   = '0;
    if (is_reg_c) begin
      // byte regs 4..7 are the high bytes of regs 0..3
      if (byte_reg_i && mrm.rm[GPR_IDX_W-1]) begin
        hi_c  = 1'b1;
        idx_c = {1'b0, mrm.rm[GPR_IDX_W-2:0]};
      end
    end else begin
      addr_c = seg + (addr16_i ? {{(WORD_W-OFF16_W){1'b0}}, off16} : off32);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      addr_o    <= '0;
      is_reg_o  <= 1'b0;
      reg_idx_o <= '0;
      reg_hi_o  <= 1'b0;
      len_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o    <= addr_c;
        is_reg_o  <= is_reg_c;
        reg_idx_o <= is_reg_c ? idx_c : '0;
        reg_hi_o  <= hi_c;
        len_o     <= len_c;
      end
    end
  end
endmodule

// File: rtl/modrm_addr_unit_chk.sv
module modrm_addr_unit_chk
  import ea_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          addr16_i,
  input  logic                          lea_i,
  input  logic                          byte_reg_i,
  input  logic [BYTE_W-1:0]             modrm_i,
  input  logic [FOLLOW_W-1:0]           follow_i,
  input  logic [NUM_GPR-1:0][WORD_W-1:0] gpr_i,
  input  logic [WORD_W-1:0]             ds_base_i,
  input  logic [WORD_W-1:0]             ss_base_i,
  input  logic                          valid_o,
  input  logic [WORD_W-1:0]             addr_o,
  input  logic                          is_reg_o,
  input  logic [GPR_IDX_W-1:0]          reg_idx_o,
  input  logic                          reg_hi_o,
  input  logic [LEN_W-1:0]              len_o
);
  AST_STROBE_TO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R11
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(addr_o) && $stable(len_o) && $stable(is_reg_o))); // R11
  AST_REG_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] == 2'b11) |=> (is_reg_o && len_o == 3'd2 && addr_o == '0)); // R9
  AST_HI_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !byte_reg_i) |=> !reg_hi_o); // R9
  AST_LEN_16BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr16_i) |=> (len_o == 3'd2 || len_o == 3'd3 || len_o == 3'd4)); // R8
  AST_LEA_16BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr16_i && lea_i && modrm_i[7:6] != 2'b11) |=> (addr_o[31:16] == '0)); // R10
  AST_DIRECT32_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !addr16_i && modrm_i[7:6] == 2'b00 && modrm_i[2:0] == 3'd5) |=> (len_o == 3'd6)); // R7
endmodule

bind modrm_addr_unit modrm_addr_unit_chk u_chk (.*);

// File: tb/sim_modrm_addr_unit.sv
module sim_modrm_addr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              valid_i = 1'b0, addr16 = 1'b0, lea = 1'b0, byte_reg = 1'b0;
  logic [7:0]        modrm = '0;
  logic [39:0]       follow = '0;
  logic [7:0][31:0]  gpr = '0;
  logic [31:0]       ds_base = '0, ss_base = '0;
  logic              valid_o, is_reg_o, reg_hi_o;
  logic [31:0]       addr_o;
  logic [2:0]        reg_idx_o, len_o;

  int checks = 0;
  int failures = 0;

  logic [31:0] e_addr;
  logic        e_isreg, e_hi;
  logic [2:0]  e_idx, e_len;

  modrm_addr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .addr16_i(addr16), .lea_i(lea),
    .byte_reg_i(byte_reg), .modrm_i(modrm), .follow_i(follow), .gpr_i(gpr),
    .ds_base_i(ds_base), .ss_base_i(ss_base), .valid_o(valid_o), .addr_o(addr_o),
    .is_reg_o(is_reg_o), .reg_idx_o(reg_idx_o), .reg_hi_o(reg_hi_o), .len_o(len_o)
  );

  function automatic logic [7:0] fbyte(input int k);
    return follow[k*8 +: 8];
  endfunction

  // expected results from the requirements
  task automatic ref_model();
    logic [1:0]  md = modrm[7:6];
    logic [2:0]  rm = modrm[2:0];
    logic [31:0] off = 0, dsp = 0, seg;
    logic [15:0] o16;
    logic        ss = 1'b0;
    int          dofs = 0;
    e_isreg = 1'b0; e_hi = 1'b0; e_idx = 3'd0; e_addr = 0;
    if (md == 2'd3) begin
      e_isreg = 1'b1; e_len = 3'd2; e_idx = rm;
      if (byte_reg && rm >= 3'd4) begin e_hi = 1'b1; e_idx = rm - 3'd4; end
      return;
    end
    if (addr16) begin
      case (md)
        2'd0: begin e_len = (rm == 3'd6) ? 3'd4 : 3'd2; if (rm == 3'd6) dsp = {16'h0, fbyte(1), fbyte(0)}; end
        2'd1: begin e_len = 3'd3; dsp = {{24{fbyte(0)[7]}}, fbyte(0)}; end
        default: begin e_len = 3'd4; dsp = {16'h0, fbyte(1), fbyte(0)}; end
      endcase
      case (rm)
        3'd0: o16 = gpr[3][15:0] + gpr[6][15:0];
        3'd1: o16 = gpr[3][15:0] + gpr[7][15:0];
        3'd2: begin o16 = gpr[5][15:0] + gpr[6][15:0]; ss = 1'b1; end
        3'd3: begin o16 = gpr[5][15:0] + gpr[7][15:0]; ss = 1'b1; end
        3'd4: o16 = gpr[6][15:0];
        3'd5: o16 = gpr[7][15:0];
        3'd6: begin o16 = (md == 2'd0) ? 16'h0 : gpr[5][15:0]; ss = (md != 2'd0); end
        default: o16 = gpr[3][15:0];
      endcase
      o16 = o16 + dsp[15:0];
      off = {16'h0, o16};
    end else begin
      if (rm == 3'd4) begin
        logic [1:0] sc = fbyte(0)[7:6];
        logic [2:0] ix = fbyte(0)[5:3];
        logic [2:0] bs = fbyte(0)[2:0];
        dofs = 1;
        if (md == 2'd0 && bs == 3'd5) off = {fbyte(4), fbyte(3), fbyte(2), fbyte(1)};
        else begin off = gpr[bs]; ss = (bs == 3'd4 || bs == 3'd5); end
        if (ix != 3'd4) off = off + (gpr[ix] << sc);
        e_len = (md == 2'd0) ? ((bs == 3'd5) ? 3'd7 : 3'd3) : (md == 2'd1) ? 3'd4 : 3'd7;
      end else if (md == 2'd0 && rm == 3'd5) begin
        e_len = 3'd6;
        off = {fbyte(3), fbyte(2), fbyte(1), fbyte(0)};
      end else begin
        off = gpr[rm];
        ss = (rm == 3'd5) && (md != 2'd0);
        e_len = (md == 2'd0) ? 3'd2 : (md == 2'd1) ? 3'd3 : 3'd6;
      end
      if (md == 2'd1) dsp = {{24{fbyte(dofs)[7]}}, fbyte(dofs)};
      if (md == 2'd2) dsp = {fbyte(dofs+3), fbyte(dofs+2), fbyte(dofs+1), fbyte(dofs)};
      off = off + dsp;
    end
    seg = lea ? 32'h0 : (ss ? ss_base : ds_base);
    e_addr = seg + off;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "valid", {31'h0, valid_o}, 32'h1);
    chk(tag, "addr", addr_o, e_addr);
    chk(tag, "is_reg", {31'h0, is_reg_o}, {31'h0, e_isreg});
    chk(tag, "idx", {29'h0, reg_idx_o}, {29'h0, e_idx});
    chk(tag, "hi", {31'h0, reg_hi_o}, {31'h0, e_hi});
    chk(tag, "len", {29'h0, len_o}, {29'h0, e_len});
  endtask

  // inputs already set at a negedge; strobe and sample the next negedge
  task automatic strobe();
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_ref(input string tag);
    ref_model();
    strobe();
    compare_all(tag);
  endtask

  task automatic run_lit(input string tag, input logic [31:0] ea, input logic [2:0] el,
                         input logic ir, input logic [2:0] ei, input logic eh);
    e_addr = ea; e_len = el; e_isreg = ir; e_idx = ei; e_hi = eh;
    strobe();
    compare_all(tag);
  endtask

  task automatic setup(input logic a16, input logic ld, input logic br, input logic [7:0] m, input logic [39:0] f);
    addr16 = a16; lea = ld; byte_reg = br; modrm = m; follow = f;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R11", "reset valid", {31'h0, valid_o}, 32'h0);
    chk("R11", "reset addr", addr_o, 32'h0);
    chk("R11", "reset len", {29'h0, len_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) gpr[i] = 32'h0;
    ds_base = 32'h0001_0000; ss_base = 32'h0002_0000;

    // R2: 16-bit direct displacement, BP ignored, DS used
    gpr[5] = 32'h5555;
    setup(1'b1, 1'b0, 1'b0, 8'h06, 40'h00_0000_1234);
    run_lit("R2", 32'h0001_1234, 3'd4, 1'b0, 3'd0, 1'b0);

    // R1: BX+SI wraps at 16 bits
    gpr[3] = 32'h0000_FFF0; gpr[6] = 32'h0000_0020;
    setup(1'b1, 1'b0, 1'b0, 8'h00, 40'h0);
    run_lit("R1", 32'h0001_0010, 3'd2, 1'b0, 3'd0, 1'b0);

    // R3/R4: BP+d8(-2) uses SS in 16-bit mode
    gpr[5] = 32'h0000_0100;
    setup(1'b1, 1'b0, 1'b0, 8'h46, 40'h00_0000_00FE);
    run_lit("R3", 32'h0002_00FE, 3'd3, 1'b0, 3'd0, 1'b0);

    // R3: SIB base ESP, no index, uses SS
    gpr[4] = 32'h0000_8000;
    setup(1'b0, 1'b0, 1'b0, 8'h04, 40'h00_0000_0024);
    run_lit("R3", 32'h0002_8000, 3'd3, 1'b0, 3'd0, 1'b0);

    // R6: no base, ECX*4 + disp32, DS
    gpr[1] = 32'h10;
    setup(1'b0, 1'b0, 1'b0, 8'h04, 40'h00_0010_008D);
    run_lit("R6", 32'h0001_1040, 3'd7, 1'b0, 3'd0, 1'b0);

    // R6: index 4 with nonzero scale adds nothing
    gpr[0] = 32'h0000_0300;
    setup(1'b0, 1'b0, 1'b0, 8'h04, 40'h00_0000_0060);
    run_lit("R6", 32'h0001_0300, 3'd3, 1'b0, 3'd0, 1'b0);

    // R5: EBX + ESI*8 + disp32
    gpr[3] = 32'h100; gpr[6] = 32'h2;
    setup(1'b0, 1'b0, 1'b0, 8'h84, 40'h00_0000_10F3);
    run_lit("R5", 32'h0001_0120, 3'd7, 1'b0, 3'd0, 1'b0);

    // R7/R11: direct disp32 with 32-bit wrap
    ds_base = 32'h3000_0000;
    setup(1'b0, 1'b0, 1'b0, 8'h05, 40'h00_DEAD_BEEF);
    run_lit("R7", 32'h0EAD_BEEF, 3'd6, 1'b0, 3'd0, 1'b0);
    ds_base = 32'h0001_0000;

    // R4: EAX + negative d8 in 32-bit mode
    gpr[0] = 32'h10;
    setup(1'b0, 1'b0, 1'b0, 8'h40, 40'h00_0000_0080);
    run_lit("R4", 32'h0000_FF90, 3'd3, 1'b0, 3'd0, 1'b0);

    // R8: mod=1 with SIB, mod=2 without SIB
    setup(1'b0, 1'b1, 1'b0, 8'h44, 40'h00_0000_0524);
    run_lit("R8", 32'h0000_8005, 3'd4, 1'b0, 3'd0, 1'b0);
    setup(1'b0, 1'b1, 1'b0, 8'h80, 40'h00_0000_0001);
    run_lit("R8", 32'h0000_0011, 3'd6, 1'b0, 3'd0, 1'b0);

    // R9: byte register CH, then word register EBP
    setup(1'b0, 1'b0, 1'b1, 8'hC5, 40'h0);
    run_lit("R9", 32'h0, 3'd2, 1'b1, 3'd1, 1'b1);
    setup(1'b0, 1'b0, 1'b0, 8'hC5, 40'h0);
    run_lit("R9", 32'h0, 3'd2, 1'b1, 3'd5, 1'b0);

    // R10: EBP+d8 with bases ignored
    gpr[5] = 32'h0000_4000;
    setup(1'b0, 1'b1, 1'b0, 8'h45, 40'h00_0000_0004);
    run_lit("R10", 32'h0000_4004, 3'd3, 1'b0, 3'd0, 1'b0);

    // R11: no strobe, changed inputs: outputs hold, valid low
    setup(1'b1, 1'b0, 1'b0, 8'h00, 40'h0);
    @(negedge clk);
    chk("R11", "hold valid", {31'h0, valid_o}, 32'h0);
    chk("R11", "hold addr", addr_o, 32'h0000_4004);
    chk("R11", "hold len", {29'h0, len_o}, 32'h3);

    for (int n = 0; n < 600; n++) begin
      string tag;
      for (int r = 0; r < 8; r++) gpr[r] = $urandom;
      ds_base = $urandom; ss_base = $urandom;
      addr16 = $urandom; lea = ($urandom % 4) == 0; byte_reg = $urandom;
      modrm = $urandom;
      follow = {$urandom, $urandom};
      if (modrm[7:6] == 2'd3)      tag = "R9";
      else if (addr16)             tag = "R1";
      else if (modrm[2:0] == 3'd4) tag = "R5";
      else                         tag = "R4";
      run_ref(tag);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule